// File: doc/BRIEF.md
# Burst Column Order Generator

This block produces the column addresses of one double-data-rate burst. A burst is requested with a one-cycle start pulse carrying the first column and a copy of the mode register. The block then walks through the burst beat by beat. Two beats move per clock cycle, one per clock edge, so each cycle it presents a pair of columns: the rising-edge beat and the falling-edge beat. A valid flag marks each pair and a last flag marks the final pair.

The burst length and the beat ordering are taken straight from mode register fields. Ordering is either sequential, where the offset counts upward and wraps inside the burst-aligned block, or interleaved, where the offset is the start column XOR the beat number. The block also returns the CAS latency latched with the request. An invalid burst length code raises an error pulse, and no burst starts.

Top module: `bco_top`

## Requirements
- R1: After reset, busy_o, pair_valid_o, pair_last_o and len_err_o are 0, and rd_lat_o is 0.
- R2: mode_i[2:0] is the burst length code c. Codes 1, 2 and 3 give a burst length of 2^c. When idle, a start_i sampled high on a clock edge starts a burst. The burst presents 2^(c-1) pairs, one per cycle, in consecutive cycles. The first pair appears right after the accepting edge, and busy_o is high exactly while pairs are presented.
- R3: With mode_i[3] = 0 (sequential order), beat i of a burst of length BL has low column bits (start mod BL + i) mod BL.
- R4: With mode_i[3] = 1 (interleaved order), beat i has low column bits (start mod BL) XOR i.
- R5: Column bits at and above bit c equal those of the start column for every beat of the burst.
- R6: In each pair, col_rise_o carries the even beat 2k and col_fall_o carries the odd beat 2k+1.
- R7: pair_last_o is high on the final pair of the burst only, and the cycle after it pair_valid_o is 0.
- R8: A start_i pulse that arrives while busy_o is high is ignored: the running burst continues unchanged with its original column, length and order.
- R9: A start_i taken while idle with a length code of 0 or 4 to 7 sets len_err_o high for exactly the next cycle, and no burst starts.
- R10: rd_lat_o equals mode_i[6:4] as sampled at the last accepted start; the read latency equals the CAS latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request, one cycle |
| start_col_i | input | COL_W | First column of the burst |
| mode_i | input | 7 | Mode register: [2:0] length code, [3] order, [6:4] CAS latency |
| busy_o | output | 1 | Burst in progress |
| pair_valid_o | output | 1 | Column pair valid this cycle |
| col_rise_o | output | COL_W | Column of the rising-edge beat |
| col_fall_o | output | COL_W | Column of the falling-edge beat |
| pair_last_o | output | 1 | Final pair of the burst |
| rd_lat_o | output | 3 | Latched CAS/read latency |
| len_err_o | output | 1 | Invalid burst length code seen on a start |

## Verification
On every cycle, the assertions check the framing rules. Busy stays up from a non-final pair to the next, and a last pair is always followed by an idle cycle. The error pulse never coincides with valid data and always follows a start. The upper column bits agree between the two beats of a pair and hold steady through a burst. The exact column values under each ordering and length, the wrap of the sequential order, the latched latency, and the proof that a second start leaves the running burst unchanged are shown only by the bench. It compares each pair against an independently computed sequence over directed corner cases and random requests.

// File: rtl/bco_pkg.sv
package bco_pkg;
    localparam int MODE_W    = 7;
    localparam int LEN_LSB   = 0;
    localparam int LEN_W     = 3;
    localparam int ORDER_BIT = 3;
    localparam int CL_LSB    = 4;
    localparam int CL_W      = 3;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;
endpackage

// File: rtl/bco_colgen.sv
module bco_colgen #(
    parameter int COL_W   = 10,
    parameter int MAX_LOG = 3
) (
    input  logic [COL_W-1:0]   base_i,
    input  logic [2:0]         len_code_i,
    input  bco_pkg::order_e    order_i,
    input  logic [MAX_LOG-1:0] beat_i,
    output logic [COL_W-1:0]   col_o
);
    logic [MAX_LOG-1:0] low_base;
    logic [MAX_LOG-1:0] low_step;
    logic [MAX_LOG-1:0] low_mask;

    assign low_base = base_i[MAX_LOG-1:0];

    always_comb begin
        for (int b = 0; b < MAX_LOG; b++) begin
            low_mask[b] = (b < int'(len_code_i));
        end
        if (order_i == bco_pkg::ORD_ILV) begin
            low_step = low_base ^ beat_i;
        end else begin
            low_step = low_base + beat_i;
        end
    end

    assign col_o = {base_i[COL_W-1:MAX_LOG], (low_base & ~low_mask) | (low_step & low_mask)};
endmodule

// File: rtl/bco_seq.sv
module bco_seq #(
    parameter int COL_W   = 10,
    parameter int MAX_LOG = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [COL_W-1:0]           start_col_i,
    input  logic [bco_pkg::MODE_W-1:0] mode_i,
    output logic                       busy_o,
    output logic                       last_o,
    output logic [MAX_LOG-2:0]         pair_idx_o,
    output logic [COL_W-1:0]           base_o,
    output logic [2:0]                 len_code_o,
    output bco_pkg::order_e            order_o,
    output logic [bco_pkg::CL_W-1:0]   rd_lat_o,
    output logic                       err_o
);
    localparam int CNT_W = MAX_LOG - 1;

    typedef struct packed {
        logic                     busy;
        logic [CNT_W-1:0]         cnt;
        logic [COL_W-1:0]         base;
        logic [2:0]               code;
        bco_pkg::order_e          order;
        logic [bco_pkg::CL_W-1:0] lat;
        logic                     err;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [2:0]       req_code;
    logic             req_ok;
    logic [CNT_W-1:0] final_cnt;

    function automatic logic [CNT_W-1:0] pairs_minus_one(input logic [2:0] code);
        int n;
        n = (code == 3'd0) ? 0 : ((1 << (int'(code) - 1)) - 1);
        return CNT_W'(n);
    endfunction

    assign req_code  = mode_i[bco_pkg::LEN_LSB +: bco_pkg::LEN_W];
    assign req_ok    = (req_code != 3'd0) && (int'(req_code) <= MAX_LOG);
    assign final_cnt = pairs_minus_one(st_q.code);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                if (req_ok) begin
                    st_d.busy  = 1'b1;
                    st_d.cnt   = '0;
                    st_d.base  = start_col_i;
                    st_d.code  = req_code;
                    st_d.order = bco_pkg::order_e'(mode_i[bco_pkg::ORDER_BIT]);
                    st_d.lat   = mode_i[bco_pkg::CL_LSB +: bco_pkg::CL_W];
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end else if (st_q.cnt == final_cnt) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = st_q.busy;
    assign last_o     = st_q.busy && (st_q.cnt == final_cnt);
    assign pair_idx_o = st_q.cnt;
    assign base_o     = st_q.base;
    assign len_code_o = st_q.code;
    assign order_o    = st_q.order;
    assign rd_lat_o   = st_q.lat;
    assign err_o      = st_q.err;
endmodule

// File: rtl/bco_top.sv
module bco_top #(
    parameter int COL_W   = 10,
    parameter int MAX_LOG = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [COL_W-1:0]           start_col_i,
    input  logic [bco_pkg::MODE_W-1:0] mode_i,
    output logic                       busy_o,
    output logic                       pair_valid_o,
    output logic [COL_W-1:0]           col_rise_o,
    output logic [COL_W-1:0]           col_fall_o,
    output logic                       pair_last_o,
    output logic [bco_pkg::CL_W-1:0]   rd_lat_o,
    output logic                       len_err_o
);
    logic [MAX_LOG-2:0] pair_idx;
    logic [COL_W-1:0]   base;
    logic [2:0]         len_code;
    bco_pkg::order_e    order;
    logic               busy;
    logic               last;
    logic [COL_W-1:0]   cols [2];

    bco_seq #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .start_col_i(start_col_i),
        .mode_i     (mode_i),
        .busy_o     (busy),
        .last_o     (last),
        .pair_idx_o (pair_idx),
        .base_o     (base),
        .len_code_o (len_code),
        .order_o    (order),
        .rd_lat_o   (rd_lat_o),
        .err_o      (len_err_o)
    );

    for (genvar g = 0; g < 2; g++) begin : g_edge
        bco_colgen #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_col (
            .base_i    (base),
            .len_code_i(len_code),
            .order_i   (order),
            .beat_i    ({pair_idx, 1'(g)}),
            .col_o     (cols[g])
        );
    end

    assign busy_o       = busy;
    assign pair_valid_o = busy;
    assign pair_last_o  = last;
    assign col_rise_o   = busy ? cols[0] : '0;
    assign col_fall_o   = busy ? cols[1] : '0;
endmodule

// File: rtl/bco_chk.sv
module bco_chk #(
    parameter int COL_W   = 10,
    parameter int MAX_LOG = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             pair_valid_o,
    input logic             pair_last_o,
    input logic [COL_W-1:0] col_rise_o,
    input logic [COL_W-1:0] col_fall_o,
    input logic             len_err_o
);
    // R2
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && !pair_last_o) |=> pair_valid_o);

    // R7
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && pair_last_o) |=> !pair_valid_o);

    // R7
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_last_o |-> pair_valid_o);

    // R9
    err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> !pair_valid_o);

    // R9
    err_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> $past(start_i));

    // R5
    upper_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> (col_rise_o[COL_W-1:MAX_LOG] == col_fall_o[COL_W-1:MAX_LOG]));

    // R5
    upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && !pair_last_o) |=> $stable(col_rise_o[COL_W-1:MAX_LOG]));

    // R6
    pair_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> (col_rise_o != col_fall_o));
endmodule

bind bco_top bco_chk #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pair_valid_o(pair_valid_o),
    .pair_last_o (pair_last_o),
    .col_rise_o  (col_rise_o),
    .col_fall_o  (col_fall_o),
    .len_err_o   (len_err_o)
);

// File: tb/bco_top_tb.sv
`timescale 1ns/1ps
module bco_top_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [6:0]       mode_i = '0;
    logic             busy_o, pair_valid_o, pair_last_o, len_err_o;
    logic [COL_W-1:0] col_rise_o, col_fall_o;
    logic [2:0]       rd_lat_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bco_top #(.COL_W(COL_W), .MAX_LOG(3)) u_dut (.*);

    function automatic logic [COL_W-1:0] ref_col(input int s, input int code, input bit ilv, input int i);
        int bl, lo, off;
        bl  = 1 << code;
        lo  = s % bl;
        off = ilv ? (lo ^ i) : ((lo + i) % bl);
        return COL_W'(s - lo + off);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one burst; optionally fires a second start during pair 0 (R8).
    task automatic run_burst(input int s, input int code, input bit ilv, input int cl, input bit poke);
        int np;
        np = 1 << (code - 1);
        @(negedge clk);
        start_i = 1'b1;
        start_col_i = COL_W'(s);
        mode_i = {3'(cl), ilv, 3'(code)};
        @(negedge clk);
        if (poke) begin
            start_col_i = COL_W'(s ^ 10'h3a5);
            mode_i = {3'(cl + 1), ~ilv, 3'd3};
        end else begin
            start_i = 1'b0;
        end
        chk("R10 latency", rd_lat_o, cl);
        for (int k = 0; k < np; k++) begin
            chk("R2 valid", pair_valid_o, 1);
            chk("R2 busy", busy_o, 1);
            chk(ilv ? "R4/R5/R6 rise col" : "R3/R5/R6 rise col", col_rise_o, ref_col(s, code, ilv, 2*k));
            chk(ilv ? "R4/R5/R6 fall col" : "R3/R5/R6 fall col", col_fall_o, ref_col(s, code, ilv, 2*k+1));
            chk("R7 last", pair_last_o, (k == np - 1) ? 1 : 0);
            if (poke) chk("R8 ignored start", rd_lat_o, cl);
            @(negedge clk);
            start_i = 1'b0;
        end
        chk("R7 idle after last", pair_valid_o, 0);
        chk("R2 busy low", busy_o, 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 valid", pair_valid_o, 0);
        chk("R1 last", pair_last_o, 0);
        chk("R1 err", len_err_o, 0);
        chk("R1 lat", rd_lat_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases: wrap in sequential, XOR in interleaved, each length
        run_burst(10'h0f5, 3, 0, 2, 0);   // sequential BL8 start 5: 5,6,7,0,1,2,3,4
        run_burst(10'h0f5, 3, 1, 3, 0);   // interleaved BL8: 5,4,7,6,1,0,3,2
        run_burst(10'h2a7, 2, 0, 2, 0);   // BL4 sequential from 3, upper bit 2 kept
        run_burst(10'h2a6, 2, 1, 5, 0);   // BL4 interleaved
        run_burst(10'h1ff, 1, 0, 2, 0);   // BL2 odd start
        run_burst(10'h1fe, 1, 1, 3, 0);
        run_burst(10'h003, 3, 0, 2, 1);   // R8 start held during burst
        run_burst(10'h001, 1, 1, 6, 1);   // R8 start during single-pair burst

        // R9 bad length codes: no burst, one-cycle error
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 3) continue;
            @(negedge clk);
            start_i = 1'b1;
            start_col_i = 10'h155;
            mode_i = {3'd2, 1'b0, 3'(c)};
            @(negedge clk);
            start_i = 1'b0;
            chk("R9 err pulse", len_err_o, 1);
            chk("R9 no burst", pair_valid_o, 0);
            @(negedge clk);
            chk("R9 err cleared", len_err_o, 0);
            chk("R9 still idle", busy_o, 0);
        end

        // Random bursts
        for (int n = 0; n < 60; n++) begin
            run_burst(int'($urandom_range(1023)), int'($urandom_range(3, 1)),
                      bit'($urandom_range(1)), int'($urandom_range(7)), bit'($urandom_range(1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule